// File: doc/BRIEF.md
# Programmable Phase-Skew Clock Bank Generator

This block builds four banks of clock outputs from a single fast sampling clock. One period of that fast clock is the skew unit (tU). A nominal output clock is N tU long. N comes from a three-level range select. A free-running phase counter runs from 0 to N-1. Each bank compares that counter with its own phase offset, so its clock can be moved earlier or later by a whole number of tU.

Banks A and B move in single-tU steps. Banks C and D move in two-tU steps. On their two outermost select codes, banks C and D give a divided or inverted clock instead of a shifted one. Each bank drives a pair of outputs that always carry the same waveform.

Every select is a three-level input, so each bank has nine settings. A new setting is taken up only at a period boundary, which keeps the outputs free of runt pulses. The block is intended for clock-distribution logic that needs fixed, programmable phase relations between groups of loads.

Top module: `skew_bank_gen`

## Requirements
- R1: The range select sets N, the number of fast ticks in one nominal period. Code 2'b00 (LOW) gives 44, 2'b10 (HIGH) gives 16, and 2'b01 or 2'b11 (MID) gives 26.
- R2: A shifted output with skew s is high when ((count - s) mod N) < floor(N/2). A negative s makes the output lead the zero-skew clock by |s| ticks. A positive s makes it lag.
- R3: Banks A and B index their select pair as idx = 3*SEL1 + SEL0, with LOW=0, MID=1 and HIGH=2. They give skew idx-4 tU, which spans -4 to +4.
- R4: Banks C and D give skew 2*(idx-4) tU for idx 1 to 7, which spans -6 to +6.
- R5: On banks C and D, idx 0 (both selects LOW) gives the nominal clock divided by 2. It is high in even-numbered periods after reset and low in odd ones.
- R6: On bank C, idx 8 (both selects HIGH) gives the nominal clock divided by 4. It is high in periods 0 and 1 of every group of four after reset.
- R7: On bank D, idx 8 gives the inverse of the zero-skew clock.
- R8: The two outputs of a bank are identical on every cycle.
- R9: Each select field is 2 bits: SEL1 sits in bits [3:2] and SEL0 in bits [1:0]. The encoding is 2'b00 LOW, 2'b01 MID and 2'b10 HIGH, and 2'b11 is treated as MID.
- R10: A change to any bank select or to the range select has no effect until the counter wraps from N-1 to 0.
- R11: A synchronous reset sets the count and the period counter to zero and loads the current selects. In the cycle after a reset edge, the outputs show phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sampling clock; one period is tU |
| rst_i | input | 1 | Synchronous reset, active high |
| range_i | input | 2 | Three-level range select |
| sel_a_i | input | 4 | Bank A select pair {SEL1, SEL0} |
| sel_b_i | input | 4 | Bank B select pair |
| sel_c_i | input | 4 | Bank C select pair |
| sel_d_i | input | 4 | Bank D select pair |
| q_a_o | output | 2 | Bank A output pair |
| q_b_o | output | 2 | Bank B output pair |
| q_c_o | output | 2 | Bank C output pair |
| q_d_o | output | 2 | Bank D output pair |

## Verification
The outputs are registered in the same cycle as the count they encode. A wrong phase count, a wrong offset or a latched select of the wrong width therefore shows up at the pins within one tick, as an edge placed one or more ticks off. A period counter that drifts shows up only at the next wrap, as a wrong divided level. Config taken up too early shows up in the cycle right after a mid-period select change. The bench sweeps every select code on every bank under all four range codes and compares each cycle against an arithmetic phase model.

// File: rtl/skew_pkg.sv
package skew_pkg;

    // Kinds of bank behaviour
    localparam int KIND_FINE = 0;  // 1 tU steps, +/-4
    localparam int KIND_DIV4 = 1;  // 2 tU steps, LL div2, HH div4
    localparam int KIND_INV  = 2;  // 2 tU steps, LL div2, HH inverted

    typedef enum logic [1:0] {
        MODE_SHIFT = 2'd0,
        MODE_DIV2  = 2'd1,
        MODE_DIV4  = 2'd2,
        MODE_INV   = 2'd3
    } bank_mode_e;

    typedef struct packed {
        bank_mode_e mode;
        logic       neg;
        logic [2:0] mag;
    } bank_cfg_t;

    // Three-level code to 0 (LOW), 1 (MID), 2 (HIGH); 2'b11 reads as MID
    function automatic logic [1:0] tri_level(input logic [1:0] code);
        return (code == 2'b11) ? 2'b01 : code;
    endfunction

    function automatic bank_cfg_t decode_sel(input int kind, input logic [3:0] sel);
        bank_cfg_t r;
        int        idx;
        int        sk;
        idx    = 3 * int'(tri_level(sel[3:2])) + int'(tri_level(sel[1:0]));
        r.mode = MODE_SHIFT;
        sk     = idx - 4;
        if (kind != KIND_FINE) begin
            sk = 2 * (idx - 4);
            if (idx == 0)
                r.mode = MODE_DIV2;
            else if (idx == 8)
                r.mode = (kind == KIND_DIV4) ? MODE_DIV4 : MODE_INV;
        end
        if (r.mode != MODE_SHIFT)
            sk = 0;
        r.neg = (sk < 0);
        r.mag = 3'((sk < 0) ? -sk : sk);
        return r;
    endfunction

endpackage

// File: rtl/skew_bank.sv
module skew_bank
    import skew_pkg::*;
#(
    parameter int KIND = KIND_FINE,
    parameter int CW   = 6,
    parameter int PAIR = 2
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [CW-1:0]   cnt_d_i,
    input  logic [CW-1:0]   n_d_i,
    input  logic [1:0]      wrap_d_i,
    input  logic [3:0]      sel_d_i,
    input  logic [CW-1:0]   cnt_q_i,
    output logic [PAIR-1:0] q_o
);

    typedef struct packed {
        logic       out;
        bank_mode_e mode;
    } bank_st_t;

    bank_st_t  st_d, st_q;
    bank_cfg_t cfg;
    logic [CW:0] n_w, cnt_w, mag_w, off_w, ph_w;
    logic        hi;

    always_comb begin
        cfg   = decode_sel(KIND, sel_d_i);
        n_w   = {1'b0, n_d_i};
        cnt_w = {1'b0, cnt_d_i};
        mag_w = {{(CW-2){1'b0}}, cfg.mag};
        off_w = cfg.neg ? (n_w - mag_w) : mag_w;
        ph_w  = (cnt_w >= off_w) ? (cnt_w - off_w) : (cnt_w + n_w - off_w);
        hi    = (ph_w < (n_w >> 1));

        st_d.mode = cfg.mode;
        unique case (cfg.mode)
            MODE_DIV2: st_d.out = ~wrap_d_i[0];
            MODE_DIV4: st_d.out = ~wrap_d_i[1];
            MODE_INV:  st_d.out = ~hi;
            default:   st_d.out = hi;
        endcase
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o = {PAIR{st_q.out}};

    // Divided outputs only move on the zero-phase boundary
    p_div_edge_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ((cnt_q_i != '0) && (st_q.mode == MODE_DIV2 || st_q.mode == MODE_DIV4))
            |-> $stable(st_q.out));

endmodule

// File: rtl/skew_bank_gen.sv
module skew_bank_gen
    import skew_pkg::*;
#(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16,
    parameter int PAIR   = 2
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [1:0]      range_i,
    input  logic [3:0]      sel_a_i,
    input  logic [3:0]      sel_b_i,
    input  logic [3:0]      sel_c_i,
    input  logic [3:0]      sel_d_i,
    output logic [PAIR-1:0] q_a_o,
    output logic [PAIR-1:0] q_b_o,
    output logic [PAIR-1:0] q_c_o,
    output logic [PAIR-1:0] q_d_o
);

    localparam int NBANK = 4;
    localparam int N_MAX = (N_LOW > N_MID) ? ((N_LOW > N_HIGH) ? N_LOW : N_HIGH)
                                           : ((N_MID > N_HIGH) ? N_MID : N_HIGH);
    localparam int CW    = $clog2(N_MAX);

    typedef struct packed {
        logic [CW-1:0]          cnt;
        logic [CW-1:0]          n;
        logic [1:0]             wrap;
        logic [NBANK-1:0][3:0]  sels;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic [NBANK-1:0][3:0] sel_in;
    logic [PAIR-1:0]       q_all [NBANK];
    logic [CW-1:0]         n_in;

    assign sel_in = {sel_d_i, sel_c_i, sel_b_i, sel_a_i};

    always_comb begin
        unique case (tri_level(range_i))
            2'b00:   n_in = CW'(N_LOW);
            2'b10:   n_in = CW'(N_HIGH);
            default: n_in = CW'(N_MID);
        endcase

        st_d = st_q;
        if (rst_i) begin
            st_d.cnt  = '0;
            st_d.wrap = '0;
            st_d.n    = n_in;
            st_d.sels = sel_in;
        end else if (st_q.cnt == st_q.n - CW'(1)) begin
            st_d.cnt  = '0;
            st_d.wrap = st_q.wrap + 2'd1;
            st_d.n    = n_in;
            st_d.sels = sel_in;
        end else begin
            st_d.cnt  = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int BK = (b < 2) ? KIND_FINE : ((b == 2) ? KIND_DIV4 : KIND_INV);
        skew_bank #(
            .KIND (BK),
            .CW   (CW),
            .PAIR (PAIR)
        ) bank_i (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .cnt_d_i  (st_d.cnt),
            .n_d_i    (st_d.n),
            .wrap_d_i (st_d.wrap),
            .sel_d_i  (st_d.sels[b]),
            .cnt_q_i  (st_q.cnt),
            .q_o      (q_all[b])
        );
    end

    assign q_a_o = q_all[0];
    assign q_b_o = q_all[1];
    assign q_c_o = q_all[2];
    assign q_d_o = q_all[3];

    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt < st_q.n);

    p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.cnt != '0) |-> ($stable(st_q.n) && $stable(st_q.sels)));

    p_wrap_step_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ((st_q.cnt == '0) && !$past(rst_i)) |-> (st_q.wrap == $past(st_q.wrap) + 2'd1));

endmodule

// File: tb/skew_bank_gen_tb_top.sv
`timescale 1ns/1ps
module skew_bank_gen_tb_top;

    logic       clk;
    logic       rst;
    logic [1:0] range_s;
    logic [3:0] sa, sb, sc, sd;
    logic [1:0] qa, qb, qc, qd;

    int vectors = 0;
    int fails   = 0;

    int         m_cnt, m_n, m_wrap;
    logic [3:0] m_sel [4];

    skew_bank_gen dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .range_i (range_s),
        .sel_a_i (sa),
        .sel_b_i (sb),
        .sel_c_i (sc),
        .sel_d_i (sd),
        .q_a_o   (qa),
        .q_b_o   (qb),
        .q_c_o   (qc),
        .q_d_o   (qd)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic int n_of(input logic [1:0] r);
        if (r == 2'b00) return 44;
        if (r == 2'b10) return 16;
        return 26;
    endfunction

    function automatic int lvl(input logic [1:0] c);
        return (c == 2'b11) ? 1 : int'(c);
    endfunction

    function automatic logic phase_hi(input int cnt, input int sk, input int n);
        int ph;
        ph = ((cnt - sk) % n + n) % n;
        return ph < (n / 2);
    endfunction

    // kind: 0 = A/B, 1 = C, 2 = D
    function automatic logic exp_out(input int kind, input int cnt, input int n,
                                     input int wrap, input logic [3:0] sel);
        int idx;
        idx = 3 * lvl(sel[3:2]) + lvl(sel[1:0]);
        if (kind == 0) return phase_hi(cnt, idx - 4, n);
        if (idx == 0) return (wrap % 2) == 0;
        if (idx == 8) begin
            if (kind == 1) return (wrap % 4) < 2;
            return !phase_hi(cnt, 0, n);
        end
        return phase_hi(cnt, 2 * (idx - 4), n);
    endfunction

    function automatic string tag_of(input int kind, input logic [3:0] sel, input logic pend);
        int    idx;
        string t;
        idx = 3 * lvl(sel[3:2]) + lvl(sel[1:0]);
        if (kind == 0)       t = "R3 R2 A/B skew";
        else if (idx == 0)   t = "R5 divide-by-2";
        else if (idx == 8)   t = (kind == 1) ? "R6 divide-by-4" : "R7 inverted";
        else                 t = "R4 R2 C/D skew";
        if (sel[3:2] == 2'b11 || sel[1:0] == 2'b11) t = {t, " R9"};
        if (pend) t = {t, " R10"};
        return t;
    endfunction

    // Reference phase model, updated on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_wrap = 0; m_n = n_of(range_s);
            m_sel[0] = sa; m_sel[1] = sb; m_sel[2] = sc; m_sel[3] = sd;
        end else if (m_cnt == m_n - 1) begin
            m_cnt = 0; m_wrap = (m_wrap + 1) % 4; m_n = n_of(range_s);
            m_sel[0] = sa; m_sel[1] = sb; m_sel[2] = sc; m_sel[3] = sd;
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b (cnt=%0d n=%0d)", req, act, exp, m_cnt, m_n);
        end
    endtask

    task automatic check_all();
        logic [1:0] q [4];
        logic       pend;
        q[0] = qa; q[1] = qb; q[2] = qc; q[3] = qd;
        pend = (n_of(range_s) != m_n) || (sa != m_sel[0]) || (sb != m_sel[1]) ||
               (sc != m_sel[2]) || (sd != m_sel[3]);
        for (int b = 0; b < 4; b++) begin
            int kind;
            kind = (b < 2) ? 0 : b - 1;
            check_bit(tag_of(kind, m_sel[b], pend), q[b][0],
                      exp_out(kind, m_cnt, m_n, m_wrap, m_sel[b]));
            check_bit("R8 pair match", q[b][1], q[b][0]);
        end
    endtask

    task automatic step(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; range_s = 2'b00;
        sa = 4'b1010; sb = 4'b0000; sc = 4'b0000; sd = 4'b0101;
        repeat (3) @(negedge clk);
        // R11: outputs show phase 0 with N=44 after reset
        check_bit("R11 reset A at +4", qa[0], 1'b0);
        check_bit("R11 reset B at -4", qb[0], 1'b1);
        check_bit("R11 reset C div2",  qc[0], 1'b1);
        check_bit("R11 reset D 0tU",   qd[0], 1'b1);
        rst = 1'b0;
        step(2 * 44);

        // Full sweep: every code on every bank under every range code
        for (int r = 0; r < 4; r++) begin
            range_s = 2'(r);
            for (int k = 0; k < 16; k++) begin
                sa = 4'(k);
                sb = 4'((k + 5) % 16);
                sc = 4'(k);
                sd = 4'((k + 9) % 16);
                step(3 * n_of(2'(r)) + 3 * k + 1);
            end
        end

        // R1: period of a 0 tU output equals N for each range code
        for (int r = 0; r < 4; r++) begin
            int   len;
            logic prev;
            range_s = 2'(r);
            sa = 4'b0101;
            step(2 * 44 + 2);
            prev = qa[0];
            while (!(qa[0] == 1'b1 && prev == 1'b0)) begin
                prev = qa[0];
                step(1);
            end
            len = 0;
            prev = qa[0];
            step(1);
            len++;
            while (!(qa[0] == 1'b1 && prev == 1'b0)) begin
                prev = qa[0];
                step(1);
                len++;
            end
            vectors++;
            if (len != n_of(2'(r))) begin
                fails++;
                $display("FAIL R1 period: actual=%0d expected=%0d", len, n_of(2'(r)));
            end
        end

        // R11: reset mid-period restarts the phase and period counters
        range_s = 2'b10;
        sa = 4'b0000; sc = 4'b1010;
        step(7);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(4 * 16);

        finish_run();
    end

endmodule